// File: doc/BRIEF.md
# Key Rotation Status Controller

This block stands between a 32-bit register bus and a slow key provider. Software asks for a fresh key by writing a renew bit. The block then holds a request toward the provider until an acknowledge returns. On that acknowledge it updates two pieces of status:

- A single-bit key-valid flag, which hardware clears again on the next accepted renew.
- A sticky 4-bit rotated field in multibit-boolean form. Only software clears this field, using a write-one-to-clear rule with the true code.

Software can clear the rotated field before each request. It then waits for the field to turn true, which gives it an acknowledge that a single flipped bit cannot forge.

A level escalation input overrides everything else. While it is high, it wipes the request and all status, keeps the flags low and blocks new requests.

The bus side always accepts. A request is one cycle with `bus_valid_i` high, and its response comes exactly one cycle later on `rsp_valid_o`. Neither side applies back-pressure, and no handshake pin exists. The register map has three registers, each with byte enables selecting bytes of the 32-bit word:

| Offset | Register | Contents |
|:-------|:---------|:---------|
| 0x00 | status, read-only | bit 0 key-valid, bit 1 seed-valid, bit 2 init-done, bit 3 request pending |
| 0x04 | control | bit 0 renew; reads as zero |
| 0x18 | rotated | rotated code in bits 3:0 |

Writes to the status register are ignored.

Top module: `keyrot_ctrl`

## Requirements
- R1: After reset:
  - the rotated field reads 0x9 (false);
  - the status word reads 0;
  - `key_req_o` is low;
  - `rotated_o` is low.
- R2: A full-enable write with bit 0 set to offset 0x04 raises `key_req_o` on the next cycle. The request stays high, however many cycles pass, until `key_ack_i` is sampled high. It drops on the same edge that updates the status.
- R3: A renew write while a request is pending has no effect. One acknowledge ends the request, and it does not restart afterwards.
- R4: The key-valid flag (status bit 0) is cleared by an accepted renew. It is set by an acknowledge taken without escalation, and otherwise holds its value.
- R5: An acknowledge taken without escalation loads 0x6 (true) into the rotated field. `rotated_o` is high exactly when the field holds 0x6.
- R6: The rotated field changes only in these cases:
  - writing the word 0x0000_0006 with full enables to offset 0x18 loads 0x9;
  - any other written value leaves it unchanged;
  - an accepted renew leaves it unchanged.
- R7: When an acknowledge and a software clear of the rotated field fall in the same cycle, the acknowledge wins and the field reads 0x6.
- R8: While `esc_i` is high:
  - the rotated field holds 0x9;
  - key-valid, seed-valid and init-done read 0;
  - any pending request is dropped;
  - renew writes and acknowledges are ignored.
- R9: Seed-valid (status bit 1) takes the value of `seed_valid_i` sampled with an accepted acknowledge.
- R10: A read of an unmapped or misaligned address returns 0xFFFF_FFFF with `rsp_err_o` high. Reads of offset 0x18 return zero in bits 31:4.
- R11: A write with any byte enable low to a mapped register sets `rsp_err_o` and has no effect.
- R12: A pulse on `init_done_i` sets init-done (status bit 2), which stays set until escalation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Register access in this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW (5) | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_be_i | input | 4 | Byte enables |
| rsp_valid_o | output | 1 | Response for the access of the previous cycle |
| rsp_rdata_o | output | 32 | Read data |
| rsp_err_o | output | 1 | Access error |
| key_req_o | output | 1 | Key request toward the provider |
| key_ack_i | input | 1 | Key acknowledge from the provider |
| seed_valid_i | input | 1 | Seed validity delivered with the acknowledge |
| init_done_i | input | 1 | Pulse marking memory initialisation complete |
| esc_i | input | 1 | Local escalation, level |
| rotated_o | output | 1 | Rotated field holds the true code |

## Verification
Two pairs of functions can collide in one cycle.

The first pair is the provider's acknowledge and a software clear of the rotated field. The bench clears the field, starts a request, and then drives the acknowledge and the 0x6 write on the same clock edge. It judges the result by reading back 0x6, since the hardware update must win.

The second pair is escalation and an acknowledge. The bench holds `esc_i` high while pulsing the acknowledge, and expects the field to stay 0x9 with key-valid low.

// File: rtl/keyrot_pkg.sv
package keyrot_pkg;

  typedef logic [3:0] mubi4_t;

  localparam mubi4_t MuTrue  = 4'h6;
  localparam mubi4_t MuFalse = 4'h9;

  // byte offsets of the register map
  localparam int unsigned OffStatus  = 32'h00;
  localparam int unsigned OffCtrl    = 32'h04;
  localparam int unsigned OffRotated = 32'h18;

  // status word bit positions
  localparam int unsigned StKeyValid  = 0;
  localparam int unsigned StSeedValid = 1;
  localparam int unsigned StInitDone  = 2;
  localparam int unsigned StPending   = 3;
  localparam int unsigned StWidth     = 4;

  typedef struct packed {
    logic key_valid;
    logic seed_valid;
    logic init_done;
    mubi4_t rotated;
  } keyrot_state_t;

  function automatic logic mubi_strict_true(mubi4_t v);
    return v == MuTrue;
  endfunction

endpackage

// File: rtl/keyrot_regif.sv
module keyrot_regif
  import keyrot_pkg::*;
#(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_valid_i,
  input  logic          bus_write_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  input  logic [DW/8-1:0] bus_be_i,
  input  logic [DW-1:0] status_word_i,
  input  mubi4_t        rot_code_i,
  output logic          renew_wr_o,
  output logic          rot_clr_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          rsp_err_o
);
  localparam int unsigned BeW = DW / 8;
  localparam logic [BeW-1:0] BeAll = '1;

  logic hit_status, hit_ctrl, hit_rot, mapped, be_full, acc_err, wr_ok;
  logic [DW-1:0] rdata_d;

  assign hit_status = bus_addr_i == AW'(OffStatus);
  assign hit_ctrl   = bus_addr_i == AW'(OffCtrl);
  assign hit_rot    = bus_addr_i == AW'(OffRotated);
  assign mapped     = hit_status | hit_ctrl | hit_rot;
  assign be_full    = bus_be_i == BeAll;

  assign acc_err = bus_valid_i & (~mapped | (bus_write_i & ~be_full));
  assign wr_ok   = bus_valid_i & bus_write_i & mapped & be_full;

  assign renew_wr_o = wr_ok & hit_ctrl & bus_wdata_i[0];
  assign rot_clr_o  = wr_ok & hit_rot & (bus_wdata_i == DW'(MuTrue));

  always_comb begin
    rdata_d = '0;
    if (!mapped)                      rdata_d = '1;
    else if (bus_write_i)             rdata_d = '0;
    else if (hit_status)              rdata_d = status_word_i;
    else if (hit_rot)                 rdata_d = DW'(rot_code_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      rsp_err_o   <= 1'b0;
    end else begin
      rsp_valid_o <= bus_valid_i;
      rsp_rdata_o <= bus_valid_i ? rdata_d : '0;
      rsp_err_o   <= acc_err;
    end
  end

  p_unmapped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_i && !mapped |=> rsp_err_o && rsp_rdata_o == '1);

  p_partial_err_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_i && bus_write_i && bus_be_i != BeAll |=> rsp_err_o);

  p_rot_upper_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_i && !bus_write_i && hit_rot |=> rsp_rdata_o[DW-1:4] == '0);

  p_rsp_one_cycle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_i |=> rsp_valid_o);

endmodule

// File: rtl/keyrot_handshake.sv
module keyrot_handshake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic renew_wr_i,
  input  logic key_ack_i,
  input  logic esc_i,
  output logic req_o,
  output logic start_o,
  output logic ack_ok_o
);
  logic req_q;

  assign start_o  = renew_wr_i & ~req_q & ~esc_i;
  assign ack_ok_o = key_ack_i & req_q & ~esc_i;
  assign req_o    = req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       req_q <= 1'b0;
    else if (esc_i)    req_q <= 1'b0;
    else if (ack_ok_o) req_q <= 1'b0;
    else if (start_o)  req_q <= 1'b1;
  end

  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && !key_ack_i && !esc_i |=> req_q);

  p_req_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && key_ack_i |=> !req_q);

  p_renew_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && renew_wr_i |-> !start_o);

  p_esc_drops_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc_i |=> !req_q);

endmodule

// File: rtl/keyrot_status.sv
module keyrot_status
  import keyrot_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          ack_ok_i,
  input  logic          seed_valid_i,
  input  logic          init_done_i,
  input  logic          rot_clr_i,
  input  logic          esc_i,
  output keyrot_state_t state_o
);
  keyrot_state_t st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q.key_valid  <= 1'b0;
      st_q.seed_valid <= 1'b0;
      st_q.init_done  <= 1'b0;
      st_q.rotated    <= MuFalse;
    end else begin
      // key-valid: hardware managed, updated on any request, ack or escalation
      if (start_i | ack_ok_i | esc_i)
        st_q.key_valid <= ack_ok_i & ~start_i & ~esc_i;

      if (esc_i)         st_q.seed_valid <= 1'b0;
      else if (ack_ok_i) st_q.seed_valid <= seed_valid_i;

      if (esc_i)            st_q.init_done <= 1'b0;
      else if (init_done_i) st_q.init_done <= 1'b1;

      // rotated: hardware update has priority over the software clear
      if (esc_i)          st_q.rotated <= MuFalse;
      else if (ack_ok_i)  st_q.rotated <= MuTrue;
      else if (rot_clr_i) st_q.rotated <= MuFalse;
    end
  end

  assign state_o = st_q;

  p_rot_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q.rotated == MuTrue || st_q.rotated == MuFalse);

  p_ack_sets_rot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_ok_i |=> st_q.rotated == MuTrue && st_q.key_valid);

  p_hw_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_ok_i && rot_clr_i |=> st_q.rotated == MuTrue);

  p_rot_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_ok_i && !esc_i && !rot_clr_i |=> $stable(st_q.rotated));

  p_esc_wipe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc_i |=> st_q.rotated == MuFalse && !st_q.key_valid && !st_q.seed_valid
              && !st_q.init_done);

  p_start_clears_kv_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !st_q.key_valid);

endmodule

// File: rtl/keyrot_ctrl.sv
module keyrot_ctrl
  import keyrot_pkg::*;
#(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_valid_i,
  input  logic            bus_write_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [DW-1:0]   bus_wdata_i,
  input  logic [DW/8-1:0] bus_be_i,
  output logic            rsp_valid_o,
  output logic [DW-1:0]   rsp_rdata_o,
  output logic            rsp_err_o,
  output logic            key_req_o,
  input  logic            key_ack_i,
  input  logic            seed_valid_i,
  input  logic            init_done_i,
  input  logic            esc_i,
  output logic            rotated_o
);
  logic renew_wr, rot_clr, start, ack_ok, req;
  keyrot_state_t st;
  logic [DW-1:0] status_word;

  keyrot_handshake u_hs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .renew_wr_i (renew_wr),
    .key_ack_i  (key_ack_i),
    .esc_i      (esc_i),
    .req_o      (req),
    .start_o    (start),
    .ack_ok_o   (ack_ok)
  );

  keyrot_status u_st (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .ack_ok_i     (ack_ok),
    .seed_valid_i (seed_valid_i),
    .init_done_i  (init_done_i),
    .rot_clr_i    (rot_clr),
    .esc_i        (esc_i),
    .state_o      (st)
  );

  always_comb begin
    status_word              = '0;
    status_word[StKeyValid]  = st.key_valid;
    status_word[StSeedValid] = st.seed_valid;
    status_word[StInitDone]  = st.init_done;
    status_word[StPending]   = req;
  end

  keyrot_regif #(.AW(AW), .DW(DW)) u_regif (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .bus_valid_i   (bus_valid_i),
    .bus_write_i   (bus_write_i),
    .bus_addr_i    (bus_addr_i),
    .bus_wdata_i   (bus_wdata_i),
    .bus_be_i      (bus_be_i),
    .status_word_i (status_word),
    .rot_code_i    (st.rotated),
    .renew_wr_o    (renew_wr),
    .rot_clr_o     (rot_clr),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_rdata_o   (rsp_rdata_o),
    .rsp_err_o     (rsp_err_o)
  );

  assign key_req_o = req;
  assign rotated_o = mubi_strict_true(st.rotated);

endmodule

// File: tb/test_keyrot_ctrl.sv
module test_keyrot_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic        rsp_valid, rsp_err, key_req, rotated;
  logic [31:0] rsp_rdata;
  logic        key_ack = 1'b0, seed_valid = 1'b0, init_done = 1'b0, esc = 1'b0;

  int checks = 0;
  int fails = 0;
  logic [31:0] rd;
  logic        er;

  always #2 clk = ~clk;

  keyrot_ctrl i_keyrot_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_valid_i(bus_valid), .bus_write_i(bus_write), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_be_i(bus_be),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .key_req_o(key_req), .key_ack_i(key_ack), .seed_valid_i(seed_valid),
    .init_done_i(init_done), .esc_i(esc), .rotated_o(rotated)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic access(logic wr, logic [4:0] a, logic [31:0] d, logic [3:0] be,
                        output logic [31:0] rdata, output logic err);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_valid = 1'b0;
    rdata = rsp_rdata; err = rsp_err;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    access(1'b1, a, d, 4'hF, rd, er);
  endtask

  task automatic rdreg(logic [4:0] a);
    access(1'b0, a, 32'h0, 4'hF, rd, er);
  endtask

  task automatic ack_pulse(logic seed);
    key_ack = 1'b1; seed_valid = seed;
    @(negedge clk);
    key_ack = 1'b0; seed_valid = 1'b0;
  endtask

  task automatic t_reset;
    rdreg(5'h18); chk("R1 rotated reset", rd, 32'h9);
    rdreg(5'h00); chk("R1 status reset", rd, 32'h0);
    chk("R1 req reset", {31'b0, key_req}, 32'h0);
    chk("R1 rotated_o reset", {31'b0, rotated}, 32'h0);
  endtask

  task automatic t_rotate;
    wr(5'h04, 32'h1);
    chk("R2 req raised", {31'b0, key_req}, 32'h1);
    repeat (300) @(negedge clk);
    chk("R2 req held over long delay", {31'b0, key_req}, 32'h1);
    rdreg(5'h00); chk("R4 kv low, pending", rd, 32'h8);
    ack_pulse(1'b1);
    chk("R2 req drops with ack", {31'b0, key_req}, 32'h0);
    rdreg(5'h00); chk("R4 R9 kv and seed set", rd, 32'h3);
    rdreg(5'h18); chk("R5 rotated true", rd, 32'h6);
    chk("R5 rotated_o high", {31'b0, rotated}, 32'h1);
  endtask

  task automatic t_renew_pending;
    wr(5'h04, 32'h1);
    rdreg(5'h18); chk("R6 renew leaves rotated", rd, 32'h6);
    repeat (5) @(negedge clk);
    wr(5'h04, 32'h1);
    chk("R3 still pending", {31'b0, key_req}, 32'h1);
    ack_pulse(1'b0);
    repeat (3) @(negedge clk);
    chk("R3 no restart after ack", {31'b0, key_req}, 32'h0);
    rdreg(5'h00); chk("R9 seed follows ack", rd, 32'h1);
  endtask

  task automatic t_w1c;
    wr(5'h18, 32'h9); rdreg(5'h18); chk("R6 write 9 ignored", rd, 32'h6);
    wr(5'h18, 32'hF); rdreg(5'h18); chk("R6 write F ignored", rd, 32'h6);
    wr(5'h18, 32'h6); rdreg(5'h18); chk("R6 write 6 clears", rd, 32'h9);
    chk("R5 rotated_o low after clear", {31'b0, rotated}, 32'h0);
    rdreg(5'h00); chk("R4 kv held across clear", rd, 32'h1);
  endtask

  task automatic t_collide;
    wr(5'h04, 32'h1);
    repeat (4) @(negedge clk);
    key_ack = 1'b1;
    access(1'b1, 5'h18, 32'h6, 4'hF, rd, er);
    key_ack = 1'b0;
    rdreg(5'h18); chk("R7 hw update wins", rd, 32'h6);
  endtask

  task automatic t_init;
    init_done = 1'b1; @(negedge clk); init_done = 1'b0;
    repeat (3) @(negedge clk);
    rdreg(5'h00); chk("R12 init done sticky", rd, 32'h5);
  endtask

  task automatic t_esc;
    wr(5'h04, 32'h1);
    esc = 1'b1; @(negedge clk);
    chk("R8 req dropped", {31'b0, key_req}, 32'h0);
    rdreg(5'h00); chk("R8 status wiped", rd, 32'h0);
    rdreg(5'h18); chk("R8 rotated false", rd, 32'h9);
    wr(5'h04, 32'h1);
    chk("R8 renew ignored", {31'b0, key_req}, 32'h0);
    ack_pulse(1'b1);
    rdreg(5'h00); chk("R8 ack ignored, kv low", rd, 32'h0);
    rdreg(5'h18); chk("R8 rotated stays false", rd, 32'h9);
    esc = 1'b0; @(negedge clk);
  endtask

  task automatic t_bus_err;
    rdreg(5'h10);
    chk("R10 unmapped data", rd, 32'hFFFF_FFFF);
    chk("R10 unmapped err", {31'b0, er}, 32'h1);
    rdreg(5'h1A); chk("R10 misaligned err", {31'b0, er}, 32'h1);
    wr(5'h04, 32'h1); ack_pulse(1'b0);
    rdreg(5'h18);
    chk("R10 rot upper zero", rd, 32'h6);
    chk("R10 rot read no err", {31'b0, er}, 32'h0);
    access(1'b1, 5'h18, 32'h6, 4'h1, rd, er);
    chk("R11 partial write err", {31'b0, er}, 32'h1);
    rdreg(5'h18); chk("R11 partial write no effect", rd, 32'h6);
    access(1'b1, 5'h04, 32'h1, 4'h7, rd, er);
    chk("R11 partial renew err", {31'b0, er}, 32'h1);
    chk("R11 partial renew no req", {31'b0, key_req}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rotate();
    t_renew_pending();
    t_w1c();
    t_collide();
    t_init();
    t_esc();
    t_bus_err();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule